// File: doc/BRIEF.md
# Brown-out Detector Enable and Start Gate

This block chooses the operating state of the supply brown-out detector from a 2-bit configuration code, a software enable bit and the CPU's sleep state. The detector can be active, in a low-power hibernate state, or switched off. The same inputs set how long the CPU must wait before it may run. After the power-on reset is released, and after a wake-up from sleep, the block holds its start permission low until the detector reports ready, in the modes that need this. When an external power-up timer is enabled, it also waits for that timer.

The analog detector and the power-up timer are outside the block. The block sees only their ready and done flags. All outputs are registered, and the reset is synchronous and active high. Holding `por_release` low has the same effect as reset on the sleep and start state. The detector outputs keep following the configuration while `por_release` is low.

Top module: `bor_enable_ctrl`

## Requirements
- R1: Reset clears `det_en`, `det_hib` and `run_ok`. The outputs encode the detector state as active (`det_en`=1, `det_hib`=0), hibernate (`det_en`=0, `det_hib`=1) or off (both 0). The two are never high together.
- R2: With `cfg_mode`=2'b11 the detector is active on the next clock, whether the CPU is awake or asleep.
- R3: With `cfg_mode`=2'b10 the detector is active while awake and hibernates while asleep. Each change is seen one clock after the edge that changes the sleep state.
- R4: With `cfg_mode`=2'b01, `sw_enable`=1 gives active and `sw_enable`=0 gives hibernate, in either sleep state. The output follows `sw_enable` one clock later.
- R5: With `cfg_mode`=2'b00 the detector is off at all times.
- R6: After `por_release` rises, `run_ok` waits for `det_ready`=1 when the code is 2'b11, 2'b10, or 2'b01 with `sw_enable`=1. For 2'b00, or 2'b01 with `sw_enable`=0, it rises on the first clock.
- R7: When `pwrt_en`=1, the first start after power-on also waits for `pwrt_done`=1. This applies in every mode.
- R8: On wake-up, `run_ok` rises on the same clock as `wake_event` in every mode except 2'b10. In 2'b10 it also waits for `det_ready`=1. The power-up timer is not consulted on wake-up.
- R9: `run_ok` falls on the clock after `sleep_enter` is seen while awake, and on the clock after `por_release` is seen low.
- R10: `wake_event` only acts while asleep, and `sleep_enter` only acts while awake. A wake-up is undone only by a later `sleep_enter`.
- R11: `sw_enable` has no effect on any output when the code is not 2'b01.
- R12: Once `run_ok` is high, it stays high until a sleep entry, a reset or a drop of `por_release`. A fall of `det_ready` or `pwrt_done` does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Detector enable configuration code |
| sw_enable | input | 1 | Software detector enable, used with code 2'b01 |
| sleep_enter | input | 1 | Pulse: CPU enters sleep |
| wake_event | input | 1 | Pulse: CPU wakes from sleep |
| por_release | input | 1 | High once the power-on reset has been released |
| det_ready | input | 1 | Ready flag from the brown-out detector |
| pwrt_en | input | 1 | Configuration: power-up timer in use |
| pwrt_done | input | 1 | Power-up timer has expired |
| det_en | output | 1 | Detector active request |
| det_hib | output | 1 | Detector hibernate request |
| run_ok | output | 1 | CPU may execute instructions |

## Verification
Several behaviours are checked by assertions on every cycle:
- the active and hibernate requests are never high together;
- the off, always-active and software-controlled codes give the detector state they define one clock later;
- the exclusive active-or-hibernate choice holds under code 2'b10;
- `run_ok` falls after a POR drop;
- `run_ok` stays high once running.

Other behaviours depend on the history of sleep and power-on events, and only the bench scenarios show them:
- the mode-dependent waits for the ready flag after power-on and after wake-up;
- the added power-up timer wait;
- the priority between sleep and wake pulses;
- the fact that the software bit is ignored outside code 2'b01.

The bench's reference model compares all three outputs on every clock.

// File: rtl/bor_pkg.sv
package bor_pkg;
  localparam int CFG_W = 2;

  localparam logic [CFG_W-1:0] CFG_OFF       = 2'b00;
  localparam logic [CFG_W-1:0] CFG_SOFTWARE  = 2'b01;
  localparam logic [CFG_W-1:0] CFG_SLEEP_HIB = 2'b10;
  localparam logic [CFG_W-1:0] CFG_ALWAYS    = 2'b11;

  typedef enum logic [1:0] {
    BOR_OFF = 2'd0,
    BOR_HIB = 2'd1,
    BOR_ACT = 2'd2
  } bor_state_e;
endpackage

// File: rtl/bor_mode_decode.sv
module bor_mode_decode
  import bor_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_mode,
  input  logic             sw_enable,
  input  logic             asleep,
  output bor_state_e       det_state,
  output logic             need_rdy_por,
  output logic             need_rdy_wake
);
  always_comb begin
    det_state     = BOR_OFF;
    need_rdy_por  = 1'b0;
    need_rdy_wake = 1'b0;
    unique case (cfg_mode)
      CFG_ALWAYS: begin
        det_state    = BOR_ACT;
        need_rdy_por = 1'b1;
      end
      CFG_SLEEP_HIB: begin
        det_state     = asleep ? BOR_HIB : BOR_ACT;
        need_rdy_por  = 1'b1;
        need_rdy_wake = 1'b1;
      end
      CFG_SOFTWARE: begin
        det_state    = sw_enable ? BOR_ACT : BOR_HIB;
        need_rdy_por = sw_enable;
      end
      default: begin
        det_state = BOR_OFF;
      end
    endcase
  end
endmodule

// File: rtl/bor_sleep_track.sv
module bor_sleep_track (
  input  logic clk,
  input  logic rst,
  input  logic por_release,
  input  logic sleep_enter,
  input  logic wake_event,
  output logic asleep_d,
  output logic asleep_q
);
  always_comb begin
    if (!por_release)  asleep_d = 1'b0;
    else if (asleep_q) asleep_d = !wake_event;
    else               asleep_d = sleep_enter;
  end

  always_ff @(posedge clk) begin
    if (rst) asleep_q <= 1'b0;
    else     asleep_q <= asleep_d;
  end
endmodule

// File: rtl/bor_start_gate.sv
module bor_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic por_release,
  input  logic asleep_d,
  input  logic need_rdy_por,
  input  logic need_rdy_wake,
  input  logic det_ready,
  input  logic pwrt_en,
  input  logic pwrt_done,
  output logic run_ok
);
  logic boot_q, boot_d;
  logic run_q, run_d;
  logic por_ok, wake_ok;

  assign por_ok  = (!need_rdy_por || det_ready) && (!pwrt_en || pwrt_done);
  assign wake_ok = !need_rdy_wake || det_ready;

  always_comb begin
    boot_d = boot_q;
    run_d  = run_q;
    if (!por_release) begin
      boot_d = 1'b1;
      run_d  = 1'b0;
    end else if (asleep_d) begin
      run_d = 1'b0;
    end else if (boot_q) begin
      run_d  = por_ok;
      boot_d = !por_ok;
    end else if (!run_q) begin
      run_d = wake_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      boot_q <= boot_d;
      run_q  <= run_d;
    end
  end

  assign run_ok = run_q;
endmodule

// File: rtl/bor_enable_ctrl.sv
module bor_enable_ctrl
  import bor_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_mode,
  input  logic             sw_enable,
  input  logic             sleep_enter,
  input  logic             wake_event,
  input  logic             por_release,
  input  logic             det_ready,
  input  logic             pwrt_en,
  input  logic             pwrt_done,
  output logic             det_en,
  output logic             det_hib,
  output logic             run_ok
);
  logic       asleep_d, asleep_q;
  bor_state_e det_state;
  logic       need_rdy_por, need_rdy_wake;
  logic       det_en_q, det_hib_q;

  bor_sleep_track u_sleep (
    .clk         (clk),
    .rst         (rst),
    .por_release (por_release),
    .sleep_enter (sleep_enter),
    .wake_event  (wake_event),
    .asleep_d    (asleep_d),
    .asleep_q    (asleep_q)
  );

  bor_mode_decode u_decode (
    .cfg_mode      (cfg_mode),
    .sw_enable     (sw_enable),
    .asleep        (asleep_d),
    .det_state     (det_state),
    .need_rdy_por  (need_rdy_por),
    .need_rdy_wake (need_rdy_wake)
  );

  bor_start_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .por_release   (por_release),
    .asleep_d      (asleep_d),
    .need_rdy_por  (need_rdy_por),
    .need_rdy_wake (need_rdy_wake),
    .det_ready     (det_ready),
    .pwrt_en       (pwrt_en),
    .pwrt_done     (pwrt_done),
    .run_ok        (run_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      det_en_q  <= 1'b0;
      det_hib_q <= 1'b0;
    end else begin
      det_en_q  <= (det_state == BOR_ACT);
      det_hib_q <= (det_state == BOR_HIB);
    end
  end

  assign det_en  = det_en_q;
  assign det_hib = det_hib_q;
endmodule

// File: rtl/bor_enable_ctrl_chk.sv
module bor_enable_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       sw_enable,
  input logic       sleep_enter,
  input logic       por_release,
  input logic       det_en,
  input logic       det_hib,
  input logic       run_ok
);
  a_r1_never_both: assert property (@(posedge clk) disable iff (rst)
    !(det_en && det_hib));

  a_r2_always_active: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b11) |=> (det_en && !det_hib));

  a_r3_one_of_two: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b10) |=> (det_en != det_hib));

  a_r4_sw_follows: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b01) |=> (det_en == $past(sw_enable) && det_hib == !$past(sw_enable)));

  a_r5_off: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b00) |=> (!det_en && !det_hib));

  a_r9_por_drop: assert property (@(posedge clk) disable iff (rst)
    !por_release |=> !run_ok);

  a_r12_run_holds: assert property (@(posedge clk) disable iff (rst)
    (run_ok && por_release && !sleep_enter) |=> run_ok);
endmodule

bind bor_enable_ctrl bor_enable_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_mode    (cfg_mode),
  .sw_enable   (sw_enable),
  .sleep_enter (sleep_enter),
  .por_release (por_release),
  .det_en      (det_en),
  .det_hib     (det_hib),
  .run_ok      (run_ok)
);

// File: tb/bor_enable_ctrl_bench.sv
`timescale 1ns/1ps
module bor_enable_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic       sw_enable = 1'b0, sleep_enter = 1'b0, wake_event = 1'b0;
  logic       por_release = 1'b0, det_ready = 1'b0, pwrt_en = 1'b0, pwrt_done = 1'b0;
  logic       det_en, det_hib, run_ok;

  always #2 clk = ~clk;

  bor_enable_ctrl u_bor_enable_ctrl (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .sw_enable(sw_enable),
    .sleep_enter(sleep_enter), .wake_event(wake_event), .por_release(por_release),
    .det_ready(det_ready), .pwrt_en(pwrt_en), .pwrt_done(pwrt_done),
    .det_en(det_en), .det_hib(det_hib), .run_ok(run_ok)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int m_sleep = 0, m_first = 1, m_run = 0, m_en = 0, m_hib = 0;
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_sleep = 0; m_first = 1; m_run = 0; m_en = 0; m_hib = 0;
    end else begin
      int ns, wait_rdy;
      if (!por_release) ns = 0;
      else if (m_sleep == 1) ns = wake_event ? 0 : 1;
      else ns = sleep_enter ? 1 : 0;
      m_en = 0; m_hib = 0;
      if (cfg_mode == 2'b11) m_en = 1;
      else if (cfg_mode == 2'b10) begin m_en = (ns == 0); m_hib = (ns == 1); end
      else if (cfg_mode == 2'b01) begin m_en = sw_enable; m_hib = !sw_enable; end
      if (!por_release) begin m_run = 0; m_first = 1; end
      else if (ns == 1) m_run = 0;
      else if (m_first == 1) begin
        wait_rdy = (cfg_mode == 2'b11 || cfg_mode == 2'b10 || (cfg_mode == 2'b01 && sw_enable));
        if ((!wait_rdy || det_ready) && (!pwrt_en || pwrt_done)) begin m_run = 1; m_first = 0; end
        else m_run = 0;
      end else if (m_run == 0) begin
        m_run = (cfg_mode != 2'b10 || det_ready) ? 1 : 0;
      end
      m_sleep = ns;
    end
  end

  task automatic chk1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk1("det_en", det_en, m_en);
      chk1("det_hib", det_hib, m_hib);
      chk1("run_ok", run_ok, m_run);
      sleep_enter = 1'b0;
      wake_event = 1'b0;
    end
  endtask

  task automatic pulse_sleep(); sleep_enter = 1'b1; step(); endtask
  task automatic pulse_wake();  wake_event = 1'b1; step(); endtask

  task automatic power_up(logic [1:0] code, logic sw);
    por_release = 1'b0; det_ready = 1'b0; cfg_mode = code; sw_enable = sw;
    step(2);
    por_release = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    step(2);
    rst = 1'b0;
    step();
    chk1("R1 reset run_ok", run_ok, 0);

    // R6 + R2: code 11 waits for ready after POR
    cur_req = "R6";
    power_up(2'b11, 1'b0);
    step(4);
    chk1("R6 hold before ready", run_ok, 0);
    det_ready = 1'b1;
    step(2);
    chk1("R6 run after ready", run_ok, 1);
    cur_req = "R2";
    pulse_sleep();
    chk1("R2 active in sleep", det_en, 1);
    cur_req = "R9";
    chk1("R9 sleep drops run", run_ok, 0);
    step(3);
    cur_req = "R8";
    det_ready = 1'b0;
    pulse_wake();
    chk1("R8 immediate wake code 11", run_ok, 1);
    cur_req = "R12";
    step(3);
    chk1("R12 run holds without ready", run_ok, 1);

    // R3 + R8: code 10
    cur_req = "R3";
    power_up(2'b10, 1'b0);
    det_ready = 1'b1;
    step(3);
    pulse_sleep();
    chk1("R3 hibernate in sleep", det_hib, 1);
    step(2);
    cur_req = "R8";
    det_ready = 1'b0;
    pulse_wake();
    chk1("R8 code 10 waits after wake", run_ok, 0);
    step(3);
    det_ready = 1'b1;
    step(2);
    chk1("R8 code 10 runs after ready", run_ok, 1);

    // R10: priorities
    cur_req = "R10";
    pulse_wake();
    step();
    sleep_enter = 1'b1; wake_event = 1'b1;
    step();
    chk1("R10 sleep wins when awake", run_ok, 0);
    sleep_enter = 1'b1;
    step(2);
    chk1("R10 sleep ignored while asleep", det_hib, 1);
    pulse_wake();
    step(2);

    // R4 + R6: code 01
    cur_req = "R4";
    power_up(2'b01, 1'b1);
    step(3);
    chk1("R6 code 01 sw1 waits", run_ok, 0);
    sw_enable = 1'b0;
    step();
    chk1("R4 sw0 hibernate", det_hib, 1);
    sw_enable = 1'b1;
    det_ready = 1'b1;
    step();
    pulse_sleep();
    chk1("R4 sw1 active in sleep", det_en, 1);
    sw_enable = 1'b0;
    step(2);
    pulse_wake();
    chk1("R8 code 01 immediate wake", run_ok, 1);
    cur_req = "R6";
    power_up(2'b01, 1'b0);
    step();
    chk1("R6 code 01 sw0 no wait", run_ok, 1);

    // R5 + R11: code 00
    cur_req = "R5";
    power_up(2'b00, 1'b0);
    step();
    chk1("R5 immediate start", run_ok, 1);
    cur_req = "R11";
    for (int k = 0; k < 6; k++) begin
      sw_enable = k[0];
      step();
      chk1("R11 sw ignored det_en", det_en, 0);
    end
    pulse_sleep();
    step(2);
    pulse_wake();
    chk1("R5 off after wake", det_hib, 0);
    cfg_mode = 2'b11;
    sw_enable = 1'b0;
    step(2);
    chk1("R11 sw ignored code 11", det_en, 1);

    // R7: power-up timer
    cur_req = "R7";
    pwrt_en = 1'b1; pwrt_done = 1'b0;
    power_up(2'b00, 1'b0);
    step(4);
    chk1("R7 wait timer", run_ok, 0);
    pwrt_done = 1'b1;
    step();
    chk1("R7 run after timer", run_ok, 1);
    pwrt_done = 1'b0;
    step(2);
    chk1("R12 timer drop ignored", run_ok, 1);
    pulse_sleep();
    step();
    pulse_wake();
    chk1("R7 timer not used on wake", run_ok, 1);

    // R9: POR drop
    cur_req = "R9";
    por_release = 1'b0;
    step();
    chk1("R9 por drop", run_ok, 0);
    pwrt_en = 1'b0;
    step(2);
    finish_run();
  end
endmodule